// File: doc/BRIEF.md
# Dot-Matrix Scroll Controller

This block drives the scroll position of a dot-matrix display. The display scanner reads a stored pattern through a window. The controller moves that window one dot at a time, either across the columns (horizontal) or across the rows (vertical). The window can wrap inside a single stored frame, or it can travel from the first stored frame into the second and then wrap. A pass runs once and stops, or it repeats without end. The end of each pass raises a sticky interrupt flag, which the host clears.

A start pulse latches the axis, the frame span and the repeat mode, and sends both offsets back to zero. After that, each step tick advances the offset of the chosen axis. The scanner places its current column and row on the scan inputs. In return it gets the source column, the source row and the frame to fetch. These come from the offset added modulo the window length, so the wrap has no visible seam.

Top module: `scroll_controller`

## Requirements
- R1: While reset is asserted, and afterwards until the first start, h_off and v_off are 0, busy is 0 and irq_n is 1.
- R2: A start sampled at a clock edge sets busy to 1 and both offsets to 0 at that edge. It also latches dir_sel (0 = horizontal, 1 = vertical), two_frame (1 = two frames) and continuous (1 = repeat). Later changes on those three inputs have no effect until the next start.
- R3: With the horizontal axis latched, each step_tick sampled while busy advances h_off by one, and v_off stays 0. Cycles without a tick, and ticks while busy is 0, leave both offsets unchanged.
- R4: With the vertical axis latched, each step_tick sampled while busy advances v_off by one, and h_off stays 0.
- R5: The last horizontal offset is COLS-1 (16) for one frame and 2*COLS-1 (33) for two frames. The last vertical offset is ROWS-1 (6) for one frame and 2*ROWS-1 (13) for two frames.
- R6: In single mode, the tick that brings the offset to its last value ends the pass. At that edge the offset takes the last value and holds it, busy falls to 0 and the interrupt flag is set.
- R7: In continuous mode, a tick while the offset is at its last value returns the offset to 0 and sets the interrupt flag. Busy stays 1.
- R8: irq_n is 0 exactly while the interrupt flag is set. irq_clear sampled at an edge clears the flag. If the flag is set and cleared at the same edge, the set wins.
- R9: A start in the same cycle as a step_tick wins, and no advance happens. A start while busy restarts the pass from offset 0.
- R10: For each axis the source position is p = (scan + offset) mod L, where L is the length of one frame (COLS or ROWS) times the latched frame count. The source index is p mod (one-frame length). src_frame is 1 when p reaches the one-frame length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Latch configuration and begin a pass from offset 0 |
| step_tick | input | 1 | Advance request, one dot per sampled pulse |
| dir_sel | input | 1 | Axis: 0 horizontal, 1 vertical |
| two_frame | input | 1 | 1 = window spans two stored frames |
| continuous | input | 1 | 1 = repeat passes, 0 = single pass |
| irq_clear | input | 1 | Clear the interrupt flag |
| scan_col | input | $clog2(COLS) | Column the scanner is drawing |
| scan_row | input | $clog2(ROWS) | Row the scanner is drawing |
| h_off | output | $clog2(2*COLS) | Horizontal window offset |
| v_off | output | $clog2(2*ROWS) | Vertical window offset |
| busy | output | 1 | Scroll in progress |
| irq_n | output | 1 | Active-low end-of-scroll interrupt |
| src_col | output | $clog2(COLS) | Stored column to fetch |
| src_row | output | $clog2(ROWS) | Stored row to fetch |
| src_frame | output | 1 | Stored frame to fetch (0 first, 1 second) |

## Verification
Two pairs of events can land on the same edge. The first pair is the end of a continuous pass, which sets the flag, and a host clear of that flag. The bench sets this up by clearing the flag, stepping to the last offset, and then driving a tick together with irq_clear. It expects irq_n to stay low. The second pair is a start and a tick: the bench drives both while a pass is running and expects the offset to be 0, not 1. A behavioural model, updated on every edge, judges both cases along with a pseudo-random tail that lets these collisions happen by chance.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  typedef enum logic {
    AXIS_H = 1'b0,
    AXIS_V = 1'b1
  } axis_e;

  typedef struct packed {
    axis_e dir;
    logic  two;
    logic  cont;
  } scroll_cfg_t;
endpackage

// File: rtl/scroll_rst_sync.sv
module scroll_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/scroll_axis.sv
module scroll_axis #(
  parameter int LEN = 17,
  localparam int OW = $clog2(2 * LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic          two_frame,
  input  logic          wrap_en,
  output logic [OW-1:0] off,
  output logic          at_last,
  output logic          pre_last
);
  localparam logic [OW-1:0] LAST_ONE = OW'(LEN - 1);
  localparam logic [OW-1:0] LAST_TWO = OW'(2 * LEN - 1);

  logic [OW-1:0] off_q;
  logic [OW-1:0] off_d;
  logic [OW-1:0] last;
  logic          off_en;

  always_comb begin
    last     = two_frame ? LAST_TWO : LAST_ONE;
    at_last  = (off_q == last);
    pre_last = (off_q == (last - OW'(1)));
  end

  always_comb begin
    off_en = clear | adv;
    off_d  = off_q;
    if (clear) begin
      off_d = '0;
    end else if (adv) begin
      if (at_last) begin
        off_d = wrap_en ? '0 : off_q;
      end else begin
        off_d = off_q + OW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  assign off = off_q;
endmodule

// File: rtl/scroll_map.sv
module scroll_map #(
  parameter int LEN = 17,
  localparam int OW = $clog2(2 * LEN),
  localparam int SW = $clog2(LEN),
  localparam int PW = OW + 1
) (
  input  logic          two_frame,
  input  logic [OW-1:0] off,
  input  logic [SW-1:0] scan,
  output logic [SW-1:0] idx,
  output logic          frame
);
  logic [PW-1:0] sum;
  logic [PW-1:0] span;
  logic [PW-1:0] pos;

  always_comb begin
    span  = two_frame ? PW'(2 * LEN) : PW'(LEN);
    sum   = {1'b0, off} + PW'(scan);
    pos   = (sum >= span) ? (sum - span) : sum;
    frame = (pos >= PW'(LEN));
    idx   = frame ? SW'(pos - PW'(LEN)) : SW'(pos);
  end
endmodule

// File: rtl/scroll_controller.sv
module scroll_controller
  import scroll_pkg::*;
#(
  parameter int COLS = 17,
  parameter int ROWS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       step_tick,
  input  logic                       dir_sel,
  input  logic                       two_frame,
  input  logic                       continuous,
  input  logic                       irq_clear,
  input  logic [$clog2(COLS)-1:0]    scan_col,
  input  logic [$clog2(ROWS)-1:0]    scan_row,
  output logic [$clog2(2*COLS)-1:0]  h_off,
  output logic [$clog2(2*ROWS)-1:0]  v_off,
  output logic                       busy,
  output logic                       irq_n,
  output logic [$clog2(COLS)-1:0]    src_col,
  output logic [$clog2(ROWS)-1:0]    src_row,
  output logic                       src_frame
);
  logic        rst_q_n;
  scroll_cfg_t cfg_q;
  scroll_cfg_t cfg_d;
  logic        busy_q;
  logic        busy_d;
  logic        busy_en;
  logic        flag_q;
  logic        flag_d;
  logic        flag_en;
  logic        tick_run;
  logic        adv_h;
  logic        adv_v;
  logic        h_last;
  logic        h_pre;
  logic        v_last;
  logic        v_pre;
  logic        sel_last;
  logic        sel_pre;
  logic        flag_set;
  logic        pass_stop;
  logic        h_frame;
  logic        v_frame;

  scroll_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // step decode and pass-end detection
  always_comb begin
    tick_run  = busy_q & step_tick & ~start;
    adv_h     = tick_run & (cfg_q.dir == AXIS_H);
    adv_v     = tick_run & (cfg_q.dir == AXIS_V);
    sel_last  = (cfg_q.dir == AXIS_V) ? v_last : h_last;
    sel_pre   = (cfg_q.dir == AXIS_V) ? v_pre  : h_pre;
    pass_stop = tick_run & ~cfg_q.cont & sel_pre;
    flag_set  = tick_run & (cfg_q.cont ? sel_last : sel_pre);
  end

  // next-state for configuration, run state and interrupt flag
  always_comb begin
    cfg_d      = start ? '{dir: axis_e'(dir_sel), two: two_frame, cont: continuous} : cfg_q;
    busy_en    = start | pass_stop;
    busy_d     = start;
    flag_en    = flag_set | irq_clear;
    flag_d     = flag_set;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cfg_q <= '{dir: AXIS_H, two: 1'b0, cont: 1'b0};
    end else if (start) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  scroll_axis #(.LEN(COLS)) u_h_axis (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clear     (start),
    .adv       (adv_h),
    .two_frame (cfg_q.two),
    .wrap_en   (cfg_q.cont),
    .off       (h_off),
    .at_last   (h_last),
    .pre_last  (h_pre)
  );

  scroll_axis #(.LEN(ROWS)) u_v_axis (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clear     (start),
    .adv       (adv_v),
    .two_frame (cfg_q.two),
    .wrap_en   (cfg_q.cont),
    .off       (v_off),
    .at_last   (v_last),
    .pre_last  (v_pre)
  );

  scroll_map #(.LEN(COLS)) u_h_map (
    .two_frame (cfg_q.two),
    .off       (h_off),
    .scan      (scan_col),
    .idx       (src_col),
    .frame     (h_frame)
  );

  scroll_map #(.LEN(ROWS)) u_v_map (
    .two_frame (cfg_q.two),
    .off       (v_off),
    .scan      (scan_row),
    .idx       (src_row),
    .frame     (v_frame)
  );

  assign src_frame = h_frame | v_frame;
  assign busy      = busy_q;
  assign irq_n     = ~flag_q;
endmodule

// File: rtl/scroll_controller_chk.sv
module scroll_controller_chk #(
  parameter int COLS = 17,
  parameter int ROWS = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      step_tick,
  input logic                      irq_clear,
  input logic [$clog2(2*COLS)-1:0] h_off,
  input logic [$clog2(2*ROWS)-1:0] v_off,
  input logic                      busy,
  input logic                      irq_n,
  input logic [$clog2(COLS)-1:0]   src_col,
  input logic [$clog2(ROWS)-1:0]   src_row
);
  AST_START_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (h_off == '0) && (v_off == '0) && busy); // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(h_off) && $stable(v_off))); // R3

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !step_tick) |=> ($stable(h_off) && $stable(v_off))); // R4

  AST_ONE_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_off == '0) || (v_off == '0)); // R3

  AST_OFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(h_off) <= 2 * COLS - 1) && (int'(v_off) <= 2 * ROWS - 1)); // R5

  AST_STOP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !irq_n); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_clear) |=> !irq_n); // R8

  AST_SRC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src_col) < COLS) && (int'(src_row) < ROWS)); // R10
endmodule

bind scroll_controller scroll_controller_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .start     (start),
  .step_tick (step_tick),
  .irq_clear (irq_clear),
  .h_off     (h_off),
  .v_off     (v_off),
  .busy      (busy),
  .irq_n     (irq_n),
  .src_col   (src_col),
  .src_row   (src_row)
);

// File: tb/scroll_controller_test.sv
module scroll_controller_test;
  localparam int COLS = 17;
  localparam int ROWS = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                      rst_n;
  logic                      start;
  logic                      step_tick;
  logic                      dir_sel;
  logic                      two_frame;
  logic                      continuous;
  logic                      irq_clear;
  logic [$clog2(COLS)-1:0]   scan_col;
  logic [$clog2(ROWS)-1:0]   scan_row;
  logic [$clog2(2*COLS)-1:0] h_off;
  logic [$clog2(2*ROWS)-1:0] v_off;
  logic                      busy;
  logic                      irq_n;
  logic [$clog2(COLS)-1:0]   src_col;
  logic [$clog2(ROWS)-1:0]   src_row;
  logic                      src_frame;

  scroll_controller #(.COLS(COLS), .ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .step_tick(step_tick),
    .dir_sel(dir_sel), .two_frame(two_frame), .continuous(continuous),
    .irq_clear(irq_clear), .scan_col(scan_col), .scan_row(scan_row),
    .h_off(h_off), .v_off(v_off), .busy(busy), .irq_n(irq_n),
    .src_col(src_col), .src_row(src_row), .src_frame(src_frame)
  );

  int total = 0;
  int bad   = 0;
  int cycn  = 0;
  int mh = 0, mv = 0, mbusy = 0, mflag = 0, mdir = 0, mtwo = 0, mcont = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int len, span, p;
    chk("R3 h_off", int'(h_off), mh);
    chk("R4 v_off", int'(v_off), mv);
    chk("R6 busy", int'(busy), mbusy);
    chk("R8 irq_n", int'(irq_n), mflag ? 0 : 1);
    len  = COLS;
    span = mtwo ? 2 * COLS : COLS;
    p    = (int'(scan_col) + mh) % span;
    chk("R10 src_col", int'(src_col), p % len);
    begin
      int fh, pr;
      fh   = (p >= COLS) ? 1 : 0;
      span = mtwo ? 2 * ROWS : ROWS;
      pr   = (int'(scan_row) + mv) % span;
      chk("R10 src_row", int'(src_row), pr % ROWS);
      chk("R10 src_frame", int'(src_frame), (fh != 0 || pr >= ROWS) ? 1 : 0);
    end
  endtask

  task automatic model_edge(bit st, bit tk, bit d, bit tw, bit ct, bit clr);
    int off, len, last, setf;
    setf = 0;
    if (st) begin
      mbusy = 1; mdir = d; mtwo = tw; mcont = ct; mh = 0; mv = 0;
    end else if (mbusy != 0 && tk) begin
      off  = mdir ? mv : mh;
      len  = mdir ? ROWS : COLS;
      last = (mtwo ? 2 * len : len) - 1;
      if (off == last) begin
        if (mcont != 0) begin off = 0; setf = 1; end
      end else if (off == last - 1 && mcont == 0) begin
        off = last; mbusy = 0; setf = 1;
      end else begin
        off++;
      end
      if (mdir != 0) mv = off; else mh = off;
    end
    if (setf != 0) mflag = 1;
    else if (clr) mflag = 0;
  endtask

  task automatic cyc(bit st, bit tk, bit d, bit tw, bit ct, bit clr);
    start = st; step_tick = tk; dir_sel = d; two_frame = tw;
    continuous = ct; irq_clear = clr;
    scan_col = ($clog2(COLS))'(cycn % COLS);
    scan_row = ($clog2(ROWS))'((cycn * 3) % ROWS);
    cycn++;
    @(posedge clk);
    model_edge(st, tk, d, tw, ct, clr);
    @(negedge clk);
    compare_all();
  endtask

  task automatic ticks(int n, bit d, bit tw, bit ct);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, d, tw, ct, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; start = 0; step_tick = 0; dir_sel = 0; two_frame = 0;
    continuous = 0; irq_clear = 0; scan_col = '0; scan_row = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset h_off", int'(h_off), 0);
    chk("R1 reset v_off", int'(v_off), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset irq_n", int'(irq_n), 1);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, 0, 0);

    // horizontal, one frame, single pass
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 busy after start", int'(busy), 1);
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1, 0, 0, 0, 0);
      if (i % 5 == 0) cyc(0, 0, 0, 0, 0, 0);
    end
    chk("R5 last h one frame", int'(h_off), 16);
    chk("R6 busy drops", int'(busy), 0);
    chk("R6 irq raised", int'(irq_n), 0);
    ticks(3, 0, 0, 0);
    chk("R3 idle ticks ignored", int'(h_off), 16);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 clear", int'(irq_n), 1);

    // horizontal, two frames, continuous
    cyc(1, 0, 0, 1, 1, 0);
    ticks(33, 0, 1, 1);
    chk("R5 last h two frame", int'(h_off), 33);
    chk("R7 no flag before wrap", int'(irq_n), 1);
    cyc(0, 1, 0, 1, 1, 0);
    chk("R7 wrap to zero", int'(h_off), 0);
    chk("R7 flag on wrap", int'(irq_n), 0);
    chk("R7 still busy", int'(busy), 1);
    cyc(0, 0, 0, 1, 1, 1);
    ticks(33, 0, 1, 1);
    cyc(0, 1, 0, 1, 1, 1);
    chk("R8 set beats clear", int'(irq_n), 0);
    ticks(4, 0, 1, 1);
    cyc(1, 1, 0, 1, 1, 0);
    chk("R9 start beats tick", int'(h_off), 0);
    cyc(0, 0, 0, 0, 0, 1);

    // vertical, one frame, continuous; inputs change mid-run
    cyc(1, 0, 1, 0, 1, 0);
    ticks(6, 0, 1, 0);
    chk("R4 v advanced", int'(v_off), 6);
    chk("R2 latched axis", int'(h_off), 0);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R2 latched continuous", int'(v_off), 0);
    chk("R7 vertical flag", int'(irq_n), 0);
    cyc(0, 0, 1, 0, 0, 1);

    // vertical, two frames, single pass
    cyc(1, 0, 1, 1, 0, 0);
    ticks(13, 1, 1, 0);
    chk("R5 last v two frame", int'(v_off), 13);
    chk("R6 v stop", int'(busy), 0);

    // pseudo-random tail
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[4:0] == 5'd0, lf[6], lf[7], lf[8], lf[9], lf[11:9] == 3'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule